// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of external interrupt sources and presents them to a set of targets. A target, called a context here, is one privilege mode on one hardware thread. Every source enters through its own gateway. A runtime bit selects, per source, whether the gateway reacts to a level or to a rising edge. The gateway forwards at most one request at a time into a pending bit. It then holds back further requests until the handler reports that it is done.

For each source the core keeps a priority. For each context it keeps an enable mask and a priority threshold. Each context gets one interrupt line, driven by a per-context arbiter that picks the best eligible pending source. Software uses a simple synchronous register port. A read of a context's claim register takes the winning source, and a write of a source number to that register completes it. A build-time switch decides what edge gateways do with edges that arrive while their source is in service: count them and deliver them again later, or throw them away.

Top module: `pic_core`

## Requirements
- R1: After a synchronous active-low reset, all priorities, enables, thresholds, pending bits and trigger bits are zero, every `irq_o` bit is low, and a claim returns 0.
- R2: A pending source reaches context c only if bit ID of context c's enable register (register kind 1, index c) is set. Source ID j uses data bit j, and bit 0 is unused.
- R3: A claim returns the eligible source with the highest priority. Among sources of equal priority, the lowest source ID wins. A source is eligible when it is pending, enabled for the claiming context and has a non-zero priority.
- R4: `irq_o[c]` is high exactly when context c has an eligible source whose priority is greater than or equal to the context's threshold (kind 2, index c). A priority strictly below the threshold does not raise the line.
- R5: A source with priority 0 never raises an interrupt line and is never returned by a claim, whatever the threshold.
- R6: A claim is a read of kind 3, index c. It returns the winning source ID and clears that source's pending bit in the same edge. When nothing is eligible it returns 0 and changes no state.
- R7: After a gateway forwards a request, it forwards nothing more for that source until a completion for that ID. A level source that is still high when it completes becomes pending again at the completion edge.
- R8: Trigger register (kind 5) bit j set makes source j edge-triggered. A one-cycle pulse then latches pending. A level held high after one request produces no further request after completion.
- R9: When QUEUE_EDGES is 1, rising edges seen while an edge source is in service are counted, saturating at 2**CNT_W-1. Each later completion delivers one of them again as a new pending request.
- R10: When QUEUE_EDGES is 0, rising edges seen while an edge source is in service are discarded, and nothing becomes pending after completion.
- R11: A completion is a write of a source ID to kind 3, index c. A completion naming an ID that is not currently claimed changes nothing.
- R12: Register reads return data with `reg_rvalid` one edge after `reg_re`. The pending register (kind 4) reads back pending source j on bit j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Interrupt sources. Bit j-1 is source ID j |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Address: kind in the top 3 bits, index in the low IDX_W bits |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one edge after reg_re |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
A source level or edge that is sampled at a rising edge sets its pending bit at that same edge. A register write also takes effect at the edge that samples it. The context lines are combinational from that state, so every `irq_o` and pending result is due one edge after the stimulus. Read and claim data appear one edge after the read strobe. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, half a period after the edge where the result is due. Two instances run with the same stimulus, one queueing edges and one dropping them, so the two edge policies are compared cycle for cycle.

// File: rtl/pic_pkg.sv
// pic_pkg: shared types and helpers for the interrupt controller core.
// Assumes: register kinds sit in the top three address bits.
package pic_pkg;

    typedef enum logic [2:0] {
        K_PRIO  = 3'd0,
        K_EN    = 3'd1,
        K_THR   = 3'd2,
        K_CLAIM = 3'd3,
        K_PEND  = 3'd4,
        K_TRIG  = 3'd5
    } reg_kind_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pic_gateway.sv
// pic_gateway: turns one raw source into single requests for the pending bit.
// It keeps one request in flight, from forward until completion.
// In edge mode it optionally queues edges that arrive during service.
// Assumes: src_i is synchronous to clk; cmpl_i only pulses while in flight.
module pic_gateway #(
    parameter bit QUEUE_EDGES = 1'b1,
    parameter int CNT_W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic cmpl_i,
    output logic fwd_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             src_d_q;
    logic             inflight_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trig;
    logic             busy;

    // Trigger event: rising edge or active level, depending on mode.
    always_comb trig = edge_mode_i ? (src_i & ~src_d_q) : src_i;

    // Source still in service after this edge's completion is applied.
    always_comb busy = inflight_q & ~cmpl_i;

    // Forward a new request when idle and a trigger or queued edge exists.
    always_comb fwd_o = ~busy & (trig | (edge_mode_i & (cnt_q != '0)));

    // Track previous source level and the in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d_q    <= 1'b0;
            inflight_q <= 1'b0;
        end else begin
            src_d_q <= src_i;
            if (fwd_o) begin
                inflight_q <= 1'b1;
            end else if (cmpl_i) begin
                inflight_q <= 1'b0;
            end
        end
    end

    generate
        if (QUEUE_EDGES) begin : g_queue
            // Count edges during service; spend one per forward from the queue.
            always_ff @(posedge clk) begin
                if (!rst_n || !edge_mode_i) begin
                    cnt_q <= '0;
                end else if (busy) begin
                    if (trig && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                end else if (fwd_o && !trig && cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            AST_QUEUE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
                edge_mode_i && busy && trig && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R9
        end else begin : g_drop
            // Edges seen during service are discarded; nothing is stored.
            always_ff @(posedge clk) begin
                cnt_q <= '0;
            end
        end
    endgenerate

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q && !cmpl_i |=> inflight_q); // R7

    AST_FWD_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |=> inflight_q); // R7

endmodule

// File: rtl/pic_arbiter.sv
// pic_arbiter: picks the best eligible source for one context and drives its line.
// Highest priority wins, the lowest ID wins ties, and priority 0 is never eligible.
// Assumes: purely combinational, so it is fed from registered state.
module pic_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [NSRC-1:0]        pend_i,
    input  logic [NSRC-1:0]        en_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thr_i,
    output logic [ID_W-1:0]        id_o,
    output logic [PRIO_W-1:0]      prio_o,
    output logic                   irq_o
);

    // Linear scan in ascending ID; strict compare keeps the lowest ID on ties.
    always_comb begin
        id_o   = '0;
        prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && en_i[i] && prio_i[i*PRIO_W +: PRIO_W] > prio_o) begin
                prio_o = prio_i[i*PRIO_W +: PRIO_W];
                id_o   = ID_W'(i + 1);
            end
        end
    end

    // Raise the line when a winner exists and meets the threshold.
    always_comb irq_o = (id_o != '0) && (prio_o >= thr_i);

endmodule

// File: rtl/pic_core.sv
// pic_core: interrupt controller top. It holds the gateways, the configuration
// registers, pending and claimed state, and one arbiter per context.
// Assumes: NSRC < DATA_W (source j uses data bit j); one register access per cycle.
module pic_core
    import pic_pkg::*;
#(
    parameter int  NSRC        = 8,
    parameter int  NCTX        = 2,
    parameter int  PRIO_W      = 3,
    parameter int  DATA_W      = 32,
    parameter bit  QUEUE_EDGES = 1'b1,
    parameter int  CNT_W       = 2,
    localparam int IDX_W       = $clog2(max_of(NSRC + 1, NCTX)),
    localparam int ADDR_W      = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic [NCTX-1:0]   irq_o
);
    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int SIDX_W = max_of($clog2(NSRC), 1);
    localparam int CTX_W  = max_of($clog2(NCTX), 1);

    reg_kind_e               kind;
    logic [IDX_W-1:0]        idx;
    logic                    src_ok;
    logic                    ctx_ok;
    logic [SIDX_W-1:0]       src_sel;
    logic [CTX_W-1:0]        ctx_sel;

    logic [NSRC*PRIO_W-1:0]  prio_q;
    logic [NSRC-1:0]         en_q [NCTX];
    logic [PRIO_W-1:0]       thr_q [NCTX];
    logic [NSRC-1:0]         trig_q;
    logic [NSRC-1:0]         pend_q;
    logic [NSRC-1:0]         claimed_q;

    logic [NSRC-1:0]         fwd;
    logic [ID_W-1:0]         win_id [NCTX];
    logic [PRIO_W-1:0]       win_prio [NCTX];

    logic                    claim_fire;
    logic [ID_W-1:0]         claim_id;
    logic [NSRC-1:0]         claim_clr;
    logic                    cmpl_wr;
    logic [ID_W-1:0]         cmpl_id;
    logic                    cmpl_ok;
    logic [NSRC-1:0]         cmpl_vec;
    logic [DATA_W-1:0]       rd_val;

    // Split the address into kind and index and qualify the index.
    always_comb begin
        kind    = reg_kind_e'(reg_addr[ADDR_W-1 -: 3]);
        idx     = reg_addr[IDX_W-1:0];
        src_ok  = (idx != '0) && (int'(idx) <= NSRC);
        ctx_ok  = int'(idx) < NCTX;
        src_sel = SIDX_W'(idx - 1'b1);
        ctx_sel = CTX_W'(idx);
    end

    // Claim decode: read of a claim register takes the context's winner.
    always_comb begin
        claim_fire = reg_re && (kind == K_CLAIM) && ctx_ok;
        claim_id   = win_id[ctx_sel];
        claim_clr  = '0;
        if (claim_fire && claim_id != '0) begin
            claim_clr = NSRC'(1) << (claim_id - 1'b1);
        end
    end

    // Completion decode: accepted only for an ID that is currently claimed.
    always_comb begin
        cmpl_wr  = reg_we && (kind == K_CLAIM) && ctx_ok;
        cmpl_id  = reg_wdata[ID_W-1:0];
        cmpl_vec = '0;
        cmpl_ok  = 1'b0;
        if (cmpl_wr && cmpl_id != '0 && int'(cmpl_id) <= NSRC) begin
            cmpl_ok  = claimed_q[cmpl_id - 1'b1];
            cmpl_vec = cmpl_ok ? (NSRC'(1) << (cmpl_id - 1'b1)) : '0;
        end
    end

    // One gateway per source.
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_gw
            pic_gateway #(
                .QUEUE_EDGES (QUEUE_EDGES),
                .CNT_W       (CNT_W)
            ) u_gw (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_i       (src_i[g]),
                .edge_mode_i (trig_q[g]),
                .cmpl_i      (cmpl_vec[g]),
                .fwd_o       (fwd[g])
            );
        end
    endgenerate

    // One arbiter per context.
    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_arb
            pic_arbiter #(
                .NSRC   (NSRC),
                .PRIO_W (PRIO_W),
                .ID_W   (ID_W)
            ) u_arb (
                .pend_i (pend_q),
                .en_i   (en_q[c]),
                .prio_i (prio_q),
                .thr_i  (thr_q[c]),
                .id_o   (win_id[c]),
                .prio_o (win_prio[c]),
                .irq_o  (irq_o[c])
            );

            AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[c] |-> (pend_q & en_q[c]) != '0); // R2

            AST_IRQ_MEETS_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[c] |-> win_prio[c] >= thr_q[c] && win_prio[c] != '0); // R4
        end
    endgenerate

    // Source priorities, written by index 1..NSRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (reg_we && kind == K_PRIO && src_ok) begin
            prio_q[src_sel*PRIO_W +: PRIO_W] <= reg_wdata[PRIO_W-1:0];
        end
    end

    // Per-context enable masks and thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (reg_we && ctx_ok) begin
            if (kind == K_EN)  en_q[ctx_sel]  <= reg_wdata[NSRC:1];
            if (kind == K_THR) thr_q[ctx_sel] <= reg_wdata[PRIO_W-1:0];
        end
    end

    // Trigger-type bits: 1 selects edge, 0 selects level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (reg_we && kind == K_TRIG) begin
            trig_q <= reg_wdata[NSRC:1];
        end
    end

    // Pending set by gateways and cleared by claims; claimed set by claims and cleared by completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            claimed_q <= '0;
        end else begin
            pend_q    <= (pend_q | fwd) & ~claim_clr;
            claimed_q <= (claimed_q | claim_clr) & ~cmpl_vec;
        end
    end

    // Read mux for all register kinds.
    always_comb begin
        rd_val = '0;
        case (kind)
            K_PRIO:  if (src_ok) rd_val = DATA_W'(prio_q[src_sel*PRIO_W +: PRIO_W]);
            K_EN:    if (ctx_ok) rd_val = DATA_W'({en_q[ctx_sel], 1'b0});
            K_THR:   if (ctx_ok) rd_val = DATA_W'(thr_q[ctx_sel]);
            K_CLAIM: if (ctx_ok) rd_val = DATA_W'(claim_id);
            K_PEND:  rd_val = DATA_W'({pend_q, 1'b0});
            K_TRIG:  rd_val = DATA_W'({trig_q, 1'b0});
            default: rd_val = '0;
        endcase
    end

    // Registered read return, one edge after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_re;
            if (reg_re) reg_rdata <= rd_val;
        end
    end

    AST_CLAIM_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        claim_clr != '0 |=> (pend_q & $past(claim_clr)) == '0); // R6

    AST_PENDING_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & claimed_q) == '0); // R7

    AST_BAD_COMPLETE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_wr && !cmpl_ok && !reg_re |=> $stable(claimed_q)); // R11

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> reg_rvalid); // R12

endmodule

// File: tb/pic_core_test.sv
// pic_core_test: directed bench with two instances, one queueing edges and one dropping them.
module pic_core_test;
    localparam int NSRC = 8;
    localparam int NCTX = 2;
    localparam int DW   = 32;
    localparam int AW   = 7;

    localparam logic [2:0] KP = 3'd0, KE = 3'd1, KT = 3'd2, KC = 3'd3, KN = 3'd4, KG = 3'd5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            we = 1'b0;
    logic            re = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata_q, rdata_d;
    logic            rvalid_q, rvalid_d;
    logic [NCTX-1:0] irq_q, irq_d;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pic_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .DATA_W(DW), .QUEUE_EDGES(1'b1), .CNT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_re(re), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_q), .reg_rvalid(rvalid_q), .irq_o(irq_q));

    pic_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .DATA_W(DW), .QUEUE_EDGES(1'b0), .CNT_W(2)) uut_drop (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_re(re), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_d), .reg_rvalid(rvalid_d), .irq_o(irq_d));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; we = 1'b0; re = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] k, input int i, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = {k, 4'(i)}; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] k, input int i, output logic [DW-1:0] q, output logic [DW-1:0] qd);
        @(negedge clk);
        re = 1'b1; addr = {k, 4'(i)};
        @(posedge clk);
        @(negedge clk);
        re = 1'b0;
        chk("R12 rvalid", {31'd0, rvalid_q}, 32'd1);
        q = rdata_q;
        qd = rdata_d;
    endtask

    task automatic pulse(input int id);
        @(negedge clk);
        src[id-1] = 1'b1;
        @(negedge clk);
        src[id-1] = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] a, b;
        do_reset();
        chk("R1 irq", 32'(irq_q), 32'd0);
        rd(KP, 1, a, b); chk("R1 prio", a, 0);
        rd(KN, 0, a, b); chk("R1 pending", a, 0);
        rd(KC, 0, a, b); chk("R1 claim", a, 0);
    endtask

    task automatic t_routing_threshold();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KP, 3, 2);
        wr(KE, 1, 32'h8);
        @(negedge clk); src[2] = 1'b1;
        @(negedge clk);
        chk("R2 only ctx1 line", 32'(irq_q), 32'h2);
        rd(KN, 0, a, b); chk("R12 pending bit3", a, 32'h8);
        wr(KT, 1, 3);
        chk("R4 below threshold", 32'(irq_q), 32'h0);
        wr(KT, 1, 2);
        chk("R4 equal threshold", 32'(irq_q), 32'h2);
        rd(KT, 1, a, b); chk("R12 threshold readback", a, 2);
    endtask

    task automatic t_prio_zero();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KE, 0, 32'h20);
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk);
        chk("R5 no line", 32'(irq_q), 0);
        rd(KC, 0, a, b); chk("R5 claim returns 0", a, 0);
        rd(KN, 0, a, b); chk("R6 empty claim keeps pending", a, 32'h20);
    endtask

    task automatic t_arbitration();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KP, 2, 3); wr(KP, 4, 5); wr(KP, 6, 5);
        wr(KE, 0, 32'h54);
        @(negedge clk); src = 8'b0010_1010;
        @(negedge clk);
        rd(KC, 0, a, b); chk("R3 highest lowest-id", a, 4);
        rd(KN, 0, a, b); chk("R6 claim clears pending", a, 32'h44);
        rd(KC, 0, a, b); chk("R3 tie second", a, 6);
        rd(KC, 0, a, b); chk("R3 lowest priority last", a, 2);
        rd(KC, 0, a, b); chk("R6 none left", a, 0);
        chk("R7 blocked line low", 32'(irq_q), 0);
    endtask

    task automatic t_level_block();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KP, 1, 1); wr(KE, 0, 32'h2);
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk);
        rd(KC, 0, a, b); chk("R6 claim id1", a, 1);
        @(negedge clk); @(negedge clk);
        rd(KN, 0, a, b); chk("R7 no re-pend while in service", a, 0);
        wr(KC, 0, 1);
        rd(KN, 0, a, b); chk("R7 level re-pends at completion", a, 32'h2);
        chk("R7 line back", 32'(irq_q), 1);
    endtask

    task automatic t_bad_complete();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KP, 2, 4); wr(KE, 0, 32'h4);
        @(negedge clk); src[1] = 1'b1;
        @(negedge clk);
        wr(KC, 0, 2);
        wr(KC, 0, 7);
        rd(KN, 0, a, b); chk("R11 pending kept", a, 32'h4);
        rd(KC, 0, a, b); chk("R11 still claimable", a, 2);
        wr(KC, 0, 5);
        @(negedge clk);
        rd(KN, 0, a, b); chk("R11 held source not re-pended", a, 0);
    endtask

    task automatic t_edge_policies();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KG, 0, 32'h18);
        wr(KP, 3, 1); wr(KP, 4, 1); wr(KE, 0, 32'h18);
        pulse(3);
        @(negedge clk);
        rd(KN, 0, a, b); chk("R8 pulse latched", a, 32'h8);
        rd(KC, 0, a, b); chk("R8 claim edge source", a, 3);
        pulse(3); pulse(3);
        rd(KN, 0, a, b); chk("R9 no pend during service", a, 0);
        wr(KC, 0, 3);
        rd(KN, 0, a, b);
        chk("R9 queued edge redelivered", a, 32'h8);
        chk("R10 dropped edges", b, 0);
        rd(KC, 0, a, b); chk("R9 claim redelivery", a, 3);
        wr(KC, 0, 3);
        rd(KN, 0, a, b); chk("R9 second redelivery", a, 32'h8);
        rd(KC, 0, a, b);
        wr(KC, 0, 3);
        rd(KN, 0, a, b); chk("R9 queue drained", a, 0);
        @(negedge clk); src[3] = 1'b1;
        @(negedge clk);
        rd(KC, 0, a, b); chk("R8 held edge claim", a, 4);
        wr(KC, 0, 4);
        rd(KN, 0, a, b); chk("R8 held level no re-request", a, 0);
    endtask

    task automatic t_saturate();
        logic [DW-1:0] a, b;
        do_reset();
        wr(KG, 0, 32'h8); wr(KP, 3, 2); wr(KE, 0, 32'h8);
        pulse(3);
        rd(KC, 0, a, b);
        for (int k = 0; k < 5; k++) pulse(3);
        for (int k = 0; k < 3; k++) begin
            wr(KC, 0, 3);
            rd(KC, 0, a, b); chk("R9 saturated redelivery", a, 3);
        end
        wr(KC, 0, 3);
        rd(KC, 0, a, b); chk("R9 saturation limit 3", a, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_routing_threshold();
        t_prio_zero();
        t_arbitration();
        t_level_block();
        t_bad_complete();
        t_edge_policies();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule